// File: doc/BRIEF.md
# Shared Multiprocessor Interrupt Distributor

The block takes a wide bank of common interrupt lines and distributes them to a small number of CPUs. Each CPU has one interrupt output. Software drives the block through two words. The command word names a line and an operation. The parameter word carries data into a command or receives the result of a read command. Each line has its own trigger mode, destination policy, target-CPU mask, round-robin pointer and pending/acknowledge flags. A pending line is offered to one CPU or to several CPUs, depending on its policy. The CPU then acknowledges it with a command that carries the CPU's own index.

Command handling is a two-state machine. In `S_IDLE` no command is in flight, and one eligible line may be delivered per cycle. A command write moves the machine to `S_EXEC` (transition "latch"). In `S_EXEC` the latched command takes effect on the next clock edge. From there the machine returns to `S_IDLE` (transition "retire"), or stays in `S_EXEC` if another command is written in the same cycle (transition "chain"). No delivery happens in `S_EXEC`. The block supports at most 256 lines.

Top module: `idu_top`

## Requirements
- R1: After reset, every bit of `irq_out` and `prm_rdata` is 0. The global enable is off. Every line has policy 0 (off) and an empty target mask.
- R2: The command word carries the line number in bits 15:8 and the opcode in bits 7:0. Opcodes: 0x00 global off, 0x01 global on, 0x02 clear, 0x03 assert, 0x04 write mode, 0x05 read status, 0x06 acknowledge, 0x07 read pending, 0x08 read mode, 0x09 write mask, 0x0A read mask. A write is latched at one edge and executed at the next edge. A read result appears on `prm_rdata` after the execute edge. Any other opcode changes nothing.
- R3: While the global enable is off, `irq_out` is all zero and no new delivery is made. Deliveries that were in progress reappear when the enable is switched back on.
- R4: The mode parameter holds the trigger mode in bit 15 (0 level, 1 pulse) and the policy in bits 7:0. Policy codes: 0 off, 1 round-robin, 2 first acceptor, 3 all targets. A policy value above 3 is stored as off. Read mode returns the stored mode in the same layout.
- R5: The target mask sits in parameter bits NCPU-1:0 and is read back in the same place. A line whose mask is all zero is never delivered.
- R6: In level mode, pending equals the input OR the software-assert latch while the policy is not off. When pending falls, every delivery of that line is withdrawn.
- R7: In pulse mode, a rising input edge sets pending. Pending stays set after the input falls, until the line is fully acknowledged or cleared.
- R8: Round-robin delivers to one CPU: the first mask bit at or above the line's pointer, wrapping around. The pointer then moves to the next set mask bit after that CPU, also wrapping.
- R9: First-acceptor signals every target CPU. The first acknowledge from any of those CPUs withdraws the line from all of them.
- R10: All-targets signals every target CPU. Each acknowledge removes only the acknowledging CPU. The acknowledged flag is set once no recipient remains.
- R11: The lowest-numbered eligible line is delivered first, and at most one line is delivered per cycle.
- R12: The status read packs bit 0 enabled (policy not off), bit 1 raw asserted (input OR assert latch), bit 2 acknowledged, bit 3 pending and bits 15:8 the round-robin pointer. The pending read returns pending in bit 0.
- R13: Assert sets the software-assert latch and the pending flag. Clear drops pending, the latch, the acknowledged flag and all deliveries of the line. An acknowledge from a CPU that is not a current recipient is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| irq_in | input | NLINES | common interrupt inputs |
| cmd_we | input | 1 | command word write strobe |
| cmd_word | input | 16 | line in 15:8, opcode in 7:0 |
| cmd_cpu | input | CW | index of the CPU issuing the command |
| prm_we | input | 1 | parameter word write strobe |
| prm_wdata | input | 32 | parameter word write data |
| prm_rdata | output | 32 | parameter word contents |
| irq_out | output | NCPU | per-CPU interrupt request |

## Verification
A command strobed before edge k takes effect at edge k+1. Its read data and output changes are therefore sampled at the falling edge after k+1. A delivery that follows needs one more edge, so `irq_out` is checked one further falling edge later. A level or pulse input change sets pending at the first edge and delivers at the second. A level release withdraws the line at the second edge after the release. The bench drives on falling edges and samples `irq_out` or `prm_rdata` at the falling edge that these counts name.

// File: rtl/idu_pkg.sv
package idu_pkg;
    typedef enum logic {S_IDLE = 1'b0, S_EXEC = 1'b1} idu_state_e;

    typedef logic [1:0] pol_t;
    localparam pol_t POL_OFF   = 2'd0;
    localparam pol_t POL_RR    = 2'd1;
    localparam pol_t POL_FIRST = 2'd2;
    localparam pol_t POL_ALL   = 2'd3;

    localparam logic [7:0] OP_GDIS  = 8'h00;
    localparam logic [7:0] OP_GEN   = 8'h01;
    localparam logic [7:0] OP_CLR   = 8'h02;
    localparam logic [7:0] OP_SET   = 8'h03;
    localparam logic [7:0] OP_WMODE = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_ACK   = 8'h06;
    localparam logic [7:0] OP_RPEND = 8'h07;
    localparam logic [7:0] OP_RMODE = 8'h08;
    localparam logic [7:0] OP_WMASK = 8'h09;
    localparam logic [7:0] OP_RMASK = 8'h0A;
endpackage

// File: rtl/idu_prio.sv
module idu_prio #(
    parameter int NL = 256,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [NL-1:0] req,
    output logic [LW-1:0] sel,
    output logic          any
);
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel = LW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/idu_pick.sv
module idu_pick #(
    parameter int N = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    input  logic [CW-1:0] start,
    output logic [CW-1:0] idx
);
    always_comb begin
        logic hit;
        hit = 1'b0;
        idx = start;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(start) + i) % N;
            if (!hit && mask[j]) begin
                idx = CW'(j);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/idu_top.sv
module idu_top
    import idu_pkg::*;
#(
    parameter int NLINES = 256,
    parameter int NCPU   = 4,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_word,
    input  logic [CW-1:0]     cmd_cpu,
    input  logic              prm_we,
    input  logic [31:0]       prm_wdata,
    output logic [31:0]       prm_rdata,
    output logic [NCPU-1:0]   irq_out
);
    idu_state_e state_q, state_d;
    logic            exec, dlv_go;
    logic [7:0]      op_q;
    logic [LW-1:0]   ln_q;
    logic [CW-1:0]   cpu_q;
    logic            gen_en;
    logic [31:0]     prm_q;

    logic [NLINES-1:0] pend, ackf, swa, pulse, in_q, elig;
    pol_t              pol   [NLINES];
    logic [NCPU-1:0]   tmask [NLINES];
    logic [NCPU-1:0]   dlv   [NLINES];
    logic [CW-1:0]     rrp   [NLINES];

    logic [LW-1:0]   sel;
    logic            any_req;
    logic [NCPU-1:0] sel_mask, dlv_tgt, a_rem;
    pol_t            sel_pol;
    logic [CW-1:0]   pick_idx, start2, next_idx;
    logic            a_hit;
    logic [31:0]     stat_word;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            ln_q    <= '0;
            cpu_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_we) begin
                op_q  <= cmd_word[7:0];
                ln_q  <= cmd_word[8 +: LW];
                cpu_q <= cmd_cpu;
            end
        end
    end

    // next state and controls
    always_comb begin
        state_d = S_IDLE;
        exec    = 1'b0;
        dlv_go  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                state_d = cmd_we ? S_EXEC : S_IDLE;
                dlv_go  = any_req;
            end
            S_EXEC: begin
                state_d = cmd_we ? S_EXEC : S_IDLE;
                exec    = 1'b1;
            end
        endcase
    end

    // eligibility and arbitration
    for (genvar l = 0; l < NLINES; l++) begin : g_elig
        assign elig[l] = gen_en & pend[l] & ~ackf[l] & ~(|dlv[l])
                       & (pol[l] != POL_OFF) & (|tmask[l]);
    end

    idu_prio #(.NL(NLINES)) u_prio (.req(elig), .sel(sel), .any(any_req));

    assign sel_mask = tmask[sel];
    assign sel_pol  = pol[sel];

    idu_pick #(.N(NCPU)) u_pick_cur (.mask(sel_mask), .start(rrp[sel]), .idx(pick_idx));
    assign start2 = (pick_idx == CW'(NCPU - 1)) ? '0 : pick_idx + 1'b1;
    idu_pick #(.N(NCPU)) u_pick_nxt (.mask(sel_mask), .start(start2), .idx(next_idx));

    assign dlv_tgt = (sel_pol == POL_RR) ? (NCPU'(1) << pick_idx) : sel_mask;

    // acknowledge and status helpers
    assign a_hit = dlv[ln_q][cpu_q];
    assign a_rem = (pol[ln_q] == POL_FIRST) ? '0 : (dlv[ln_q] & ~(NCPU'(1) << cpu_q));
    assign stat_word = {16'b0, 8'(rrp[ln_q]), 4'b0, pend[ln_q], ackf[ln_q],
                        irq_in[ln_q] | swa[ln_q], pol[ln_q] != POL_OFF};

    // per-line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0; ackf <= '0; swa <= '0; pulse <= '0; in_q <= '0;
            for (int l = 0; l < NLINES; l++) begin
                pol[l] <= POL_OFF; tmask[l] <= '0; dlv[l] <= '0; rrp[l] <= '0;
            end
        end else begin
            for (int l = 0; l < NLINES; l++) begin
                in_q[l] <= irq_in[l];
                if (pol[l] == POL_OFF)
                    pend[l] <= 1'b0;
                else if (pulse[l]) begin
                    if (irq_in[l] && !in_q[l]) pend[l] <= 1'b1;
                end else
                    pend[l] <= irq_in[l] | swa[l];
                if (!pend[l]) begin
                    ackf[l] <= 1'b0;
                    dlv[l]  <= '0;
                end
            end
            if (dlv_go) begin
                dlv[sel] <= dlv_tgt;
                if (sel_pol == POL_RR) rrp[sel] <= next_idx;
            end
            if (exec) begin
                case (op_q)
                    OP_CLR: begin
                        pend[ln_q] <= 1'b0; swa[ln_q] <= 1'b0;
                        ackf[ln_q] <= 1'b0; dlv[ln_q] <= '0;
                    end
                    OP_SET: begin
                        swa[ln_q] <= 1'b1;
                        if (pol[ln_q] != POL_OFF) pend[ln_q] <= 1'b1;
                    end
                    OP_WMODE: begin
                        pulse[ln_q] <= prm_q[15];
                        pol[ln_q]   <= (prm_q[7:2] == 6'd0) ? prm_q[1:0] : POL_OFF;
                    end
                    OP_WMASK: tmask[ln_q] <= prm_q[NCPU-1:0];
                    OP_ACK: begin
                        if (a_hit) begin
                            dlv[ln_q] <= a_rem;
                            if (a_rem == '0) begin
                                ackf[ln_q] <= 1'b1;
                                if (pulse[ln_q]) pend[ln_q] <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // global enable and parameter word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            prm_q  <= '0;
        end else begin
            if (prm_we) prm_q <= prm_wdata;
            if (exec) begin
                case (op_q)
                    OP_GDIS:  gen_en <= 1'b0;
                    OP_GEN:   gen_en <= 1'b1;
                    OP_RSTAT: prm_q  <= stat_word;
                    OP_RPEND: prm_q  <= {31'b0, pend[ln_q]};
                    OP_RMODE: prm_q  <= {16'b0, pulse[ln_q], 13'b0, pol[ln_q]};
                    OP_RMASK: prm_q  <= 32'(tmask[ln_q]);
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        logic [NCPU-1:0] acc;
        acc = '0;
        for (int l = 0; l < NLINES; l++) acc = acc | dlv[l];
        irq_out = gen_en ? acc : '0;
    end

    assign prm_rdata = prm_q;
endmodule

// File: rtl/idu_chk.sv
module idu_chk
    import idu_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_we,
    input logic            exec,
    input logic            dlv_go,
    input logic [7:0]      op,
    input pol_t            sel_pol,
    input logic [NCPU-1:0] sel_mask,
    input logic [NCPU-1:0] dlv_tgt,
    input logic [NCPU-1:0] irq_out
);
    a_r2_exec_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> exec);

    a_r11_no_delivery_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> !dlv_go);

    a_r8_rr_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_go && sel_pol == POL_RR) |-> $countones(dlv_tgt) == 1);

    a_r5_target_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_go |-> ((dlv_tgt & ~sel_mask) == '0) && (dlv_tgt != '0));

    a_r3_disable_quiets_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_GDIS) |=> irq_out == '0);
endmodule

bind idu_top idu_chk #(.NCPU(NCPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .exec(exec), .dlv_go(dlv_go),
    .op(op_q), .sel_pol(sel_pol), .sel_mask(sel_mask), .dlv_tgt(dlv_tgt),
    .irq_out(irq_out)
);

// File: tb/idu_top_tb.sv
module idu_top_tb;
    localparam int NL = 256;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          cmd_we = 1'b0;
    logic [15:0]   cmd_word = '0;
    logic [1:0]    cmd_cpu = '0;
    logic          prm_we = 1'b0;
    logic [31:0]   prm_wdata = '0;
    logic [31:0]   prm_rdata;
    logic [NC-1:0] irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int rr_m [NL];

    always #2 clk = ~clk;

    idu_top u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_we(cmd_we),
        .cmd_word(cmd_word), .cmd_cpu(cmd_cpu), .prm_we(prm_we),
        .prm_wdata(prm_wdata), .prm_rdata(prm_rdata), .irq_out(irq_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] op, input int line, input int cpu);
        @(negedge clk);
        cmd_we = 1'b1; cmd_word = {8'(line), op}; cmd_cpu = 2'(cpu);
        @(negedge clk);
        cmd_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic setp(input logic [31:0] v);
        @(negedge clk);
        prm_we = 1'b1; prm_wdata = v;
        @(negedge clk);
        prm_we = 1'b0;
    endtask

    task automatic cfg(input int line, input logic [31:0] mode, input logic [31:0] mask);
        setp(mode); cmd(8'h04, line, 0);
        setp(mask); cmd(8'h09, line, 0);
    endtask

    function automatic int pick(input logic [3:0] m, input int p);
        for (int i = 0; i < NC; i++) if (m[(p + i) % NC]) return (p + i) % NC;
        return p;
    endfunction

    function automatic int low_bit(input logic [3:0] m);
        for (int i = 0; i < NC; i++) if (m[i]) return i;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) rr_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        chk("R1 prm_rdata", prm_rdata, 32'h0);

        // R4 / R5 mode and mask readback
        cfg(5, 32'h0000_0003, 32'h6);
        cmd(8'h08, 5, 0); chk("R4 read mode", prm_rdata, 32'h0000_0003);
        cmd(8'h09 + 8'h01, 5, 0); chk("R5 read mask", prm_rdata, 32'h6);
        setp(32'h0000_8007); cmd(8'h04, 7, 0);
        cmd(8'h08, 7, 0); chk("R4 bad policy stored off", prm_rdata, 32'h0000_8000);

        // R3 nothing delivered while globally off
        irq_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 off no delivery", 32'(irq_out), 32'h0);
        cmd(8'h01, 0, 0);
        @(negedge clk);
        chk("R10 all targets", 32'(irq_out), 32'h6);
        cmd(8'h06, 5, 0);
        chk("R13 ack from non-recipient", 32'(irq_out), 32'h6);
        cmd(8'h06, 5, 1);
        chk("R10 partial ack", 32'(irq_out), 32'h4);
        cmd(8'h05, 5, 0); chk("R12 status pending", prm_rdata, 32'h0000_000B);
        cmd(8'h06, 5, 2);
        chk("R10 final ack", 32'(irq_out), 32'h0);
        cmd(8'h05, 5, 0); chk("R12 status acked", prm_rdata, 32'h0000_000F);
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        cmd(8'h05, 5, 0); chk("R6 status after release", prm_rdata, 32'h0000_0001);

        // R3 disable / re-enable, R6 withdraw on release
        irq_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 level redelivered", 32'(irq_out), 32'h6);
        cmd(8'h00, 0, 0); chk("R3 disabled quiet", 32'(irq_out), 32'h0);
        cmd(8'h01, 0, 0); chk("R3 re-enabled", 32'(irq_out), 32'h6);
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 release withdraws", 32'(irq_out), 32'h0);

        // R7 / R9 pulse, first acceptor
        cfg(9, 32'h0000_8002, 32'hB);
        irq_in[9] = 1'b1;
        @(negedge clk);
        irq_in[9] = 1'b0;
        @(negedge clk);
        chk("R9 first-acceptor offer", 32'(irq_out), 32'hB);
        repeat (4) @(negedge clk);
        chk("R7 pulse held", 32'(irq_out), 32'hB);
        cmd(8'h06, 9, 3); chk("R9 withdrawn from all", 32'(irq_out), 32'h0);
        cmd(8'h07, 9, 0); chk("R7 pending cleared by ack", prm_rdata, 32'h0);

        // R8 round robin, R13 assert
        cfg(20, 32'h0000_8001, 32'hA);
        cmd(8'h03, 20, 0); @(negedge clk);
        chk("R8 rr first", 32'(irq_out), 32'h2);
        cmd(8'h05, 20, 0); chk("R12 rr pointer", prm_rdata, 32'h0000_030B);
        cmd(8'h06, 20, 1);
        cmd(8'h03, 20, 0); @(negedge clk);
        chk("R8 rr second", 32'(irq_out), 32'h8);
        cmd(8'h06, 20, 3);
        cmd(8'h03, 20, 0); @(negedge clk);
        chk("R8 rr wrap", 32'(irq_out), 32'h2);
        cmd(8'h02, 20, 0); chk("R13 clear withdraws", 32'(irq_out), 32'h0);
        cmd(8'h07, 20, 0); chk("R13 clear drops pending", prm_rdata, 32'h0);
        rr_m[20] = 3;

        // R11 priority
        cfg(30, 32'h0000_8003, 32'h1);
        cfg(40, 32'h0000_8003, 32'h2);
        irq_in[30] = 1'b1; irq_in[40] = 1'b1;
        @(negedge clk);
        irq_in[30] = 1'b0; irq_in[40] = 1'b0;
        @(negedge clk);
        chk("R11 lower line first", 32'(irq_out), 32'h1);
        @(negedge clk);
        chk("R11 then next line", 32'(irq_out), 32'h3);
        cmd(8'h06, 30, 0); cmd(8'h06, 40, 1);
        chk("R11 both acked", 32'(irq_out), 32'h0);

        // R5 empty mask, R2 unknown opcode
        cfg(50, 32'h0000_0003, 32'h0);
        cmd(8'h03, 50, 0); @(negedge clk);
        chk("R5 empty mask blocks", 32'(irq_out), 32'h0);
        cmd(8'h07, 50, 0); chk("R13 assert sets pending", prm_rdata, 32'h1);
        cmd(8'h02, 50, 0);
        setp(32'h0000_1234); cmd(8'h0F, 50, 0);
        chk("R2 unknown opcode", prm_rdata, 32'h0000_1234);

        // constrained random over lines 100..249
        for (int it = 0; it < 40; it++) begin
            int ln, pl, tgt;
            logic [3:0] m;
            ln = 100 + int'($urandom % 150);
            pl = 1 + int'($urandom % 3);
            m  = 4'(1 + $urandom % 15);
            cfg(ln, 32'h8000 | 32'(pl), 32'(m));
            cmd(8'h03, ln, 0); @(negedge clk);
            if (pl == 1) begin
                tgt = pick(m, rr_m[ln]);
                rr_m[ln] = pick(m, (tgt + 1) % NC);
                chk("R8 random rr", 32'(irq_out), 32'(1) << tgt);
                cmd(8'h06, ln, tgt);
            end else if (pl == 2) begin
                chk("R9 random first", 32'(irq_out), 32'(m));
                cmd(8'h06, ln, low_bit(m));
            end else begin
                chk("R10 random all", 32'(irq_out), 32'(m));
                for (int c = 0; c < NC; c++) if (m[c]) cmd(8'h06, ln, c);
            end
            chk("R10 random drained", 32'(irq_out), 32'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule